// File: doc/BRIEF.md
# Token-Synchronized Stream Node

This block lets a fixed-latency arithmetic pipeline act as one node of a static data-flow graph. Three operand streams arrive on their own ports, each with data, valid and ready. Every port has a small FIFO of its own. The node starts an operation only when all three FIFOs hold an element. It then removes one element from each FIFO in the same cycle and sends the triple into a pipeline that computes `a*b + c`, truncated to the data width.

A one-bit token travels beside each datum in the pipeline, so the node knows locally which stages carry real results. If the last stage holds a token and the consumer is not ready, the whole pipeline stops, tokens included. While it is stopped the node fires nothing. The FIFOs then fill and lower their ready signals, so back pressure reaches each producer. Stages without a token never cause a stop. No controller outside the node takes part in any of this.

Top module: `dfnode_wrap`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is low and `a_ready`, `b_ready` and `c_ready` are all high.
- R2: Each result on `out_data` equals the low DATA_W bits of `a*b + c`, computed on the operands of one triple, with wrap-around on overflow.
- R3: With an empty pipeline and `out_ready` high, `out_valid` rises right after the LAT-th rising edge following the edge that accepts the last element of a triple. LAT defaults to 4.
- R4: No operation starts until all three input FIFOs are non-empty. Partial operands wait and produce no output.
- R5: A port's ready is low exactly when its FIFO holds FIFO_DEPTH elements (default 2). A full FIFO frees a slot only when the node fires.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` is unchanged, and no element is taken from any FIFO.
- R7: Pipeline stages without a token do not stall. A result moves to the last stage with the usual latency even while `out_ready` is low.
- R8: Each accepted triple yields exactly one result, and results leave in acceptance order under any pattern of valid and ready.
- R9: With all three inputs valid every cycle and `out_ready` high, the node delivers one result per cycle and no input ready ever drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_data | input | DATA_W | Multiplicand operand |
| a_valid | input | 1 | Multiplicand element present |
| a_ready | output | 1 | Multiplicand FIFO can take an element |
| b_data | input | DATA_W | Multiplier operand |
| b_valid | input | 1 | Multiplier element present |
| b_ready | output | 1 | Multiplier FIFO can take an element |
| c_data | input | DATA_W | Addend operand |
| c_valid | input | 1 | Addend element present |
| c_ready | output | 1 | Addend FIFO can take an element |
| out_data | output | DATA_W | Result of the multiply-add |
| out_valid | output | 1 | Result token at the last stage |
| out_ready | input | 1 | Consumer accepts the result |

## Verification
A token bit that is set or cleared wrongly in a middle stage first shows up LAT cycles later at the output. It appears as a missing result, an extra result, or a result that does not match its operand triple in the in-order comparison. A FIFO count that drifts shows at once on the ready ports: ready stays high when the FIFO is full, or low after a pop. It shows a few cycles later as lost or repeated operands. A stall condition that is wrong shows in the very next cycle. `out_data` changes while it is held, or the pipeline waits even though the last stage is empty.

// File: rtl/dfnode_pkg.sv
package dfnode_pkg;
    // Number of operand streams joined by the node and their slot positions
    localparam int unsigned NUM_PORTS = 3;
    localparam int unsigned PORT_A    = 0;
    localparam int unsigned PORT_B    = 1;
    localparam int unsigned PORT_C    = 2;
endpackage

// File: rtl/dfnode_infifo.sv
module dfnode_infifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         deq,
    output logic [W-1:0] head_data,
    output logic         not_empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_s;

    fifo_s st_d, st_q;
    logic  push, pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign in_ready  = (st_q.cnt != CW'(DEPTH));
    assign not_empty = (st_q.cnt != '0);
    assign head_data = st_q.mem[st_q.rp];
    assign push      = in_valid & in_ready;
    assign pop       = deq & not_empty;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = in_data;
            st_d.wp           = bump(st_q.wp);
        end
        if (pop) begin
            st_d.rp = bump(st_q.rp);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dfnode_join.sv
module dfnode_join #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] have_tok,
    input  logic         tail_tok,
    input  logic         out_ready,
    output logic         advance,
    output logic         fire
);
    // Only a real token blocked at the tail holds the pipeline
    assign advance = !(tail_tok && !out_ready);
    assign fire    = (&have_tok) && advance;
endmodule

// File: rtl/dfnode_madd_pipe.sv
module dfnode_madd_pipe #(
    parameter int unsigned W   = 32,
    parameter int unsigned LAT = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic         fire,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    output logic         tail_tok,
    output logic [W-1:0] tail_data
);
    typedef struct packed {
        logic [LAT-1:0]          tok;
        logic [LAT-1:0][W-1:0]   dat;
    } pipe_s;

    pipe_s          st_d, st_q;
    logic [2*W-1:0] prod;
    logic [W-1:0]   madd;

    assign prod = op_a * op_b;
    assign madd = prod[W-1:0] + op_c;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.tok[0] = fire;
            if (fire) begin
                st_d.dat[0] = madd;
            end
            for (int i = 1; i < int'(LAT); i++) begin
                st_d.tok[i] = st_q.tok[i-1];
                st_d.dat[i] = st_q.dat[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tail_tok  = st_q.tok[LAT-1];
    assign tail_data = st_q.dat[LAT-1];
endmodule

// File: rtl/dfnode_wrap.sv
module dfnode_wrap #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LAT        = 4,
    parameter int unsigned FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [DATA_W-1:0] c_data,
    input  logic              c_valid,
    output logic              c_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    import dfnode_pkg::*;

    logic [NUM_PORTS-1:0][DATA_W-1:0] port_data;
    logic [NUM_PORTS-1:0][DATA_W-1:0] head_data;
    logic [NUM_PORTS-1:0]             port_valid;
    logic [NUM_PORTS-1:0]             port_ready;
    logic [NUM_PORTS-1:0]             have_tok;
    logic                             fire;
    logic                             advance;
    logic                             tail_tok;
    logic [DATA_W-1:0]                tail_data;

    assign port_data[PORT_A]  = a_data;
    assign port_data[PORT_B]  = b_data;
    assign port_data[PORT_C]  = c_data;
    assign port_valid[PORT_A] = a_valid;
    assign port_valid[PORT_B] = b_valid;
    assign port_valid[PORT_C] = c_valid;
    assign a_ready = port_ready[PORT_A];
    assign b_ready = port_ready[PORT_B];
    assign c_ready = port_ready[PORT_C];

    for (genvar g = 0; g < int'(NUM_PORTS); g++) begin : g_port
        dfnode_infifo #(
            .W     (DATA_W),
            .DEPTH (FIFO_DEPTH)
        ) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .in_data   (port_data[g]),
            .in_valid  (port_valid[g]),
            .in_ready  (port_ready[g]),
            .deq       (fire),
            .head_data (head_data[g]),
            .not_empty (have_tok[g])
        );
    end

    dfnode_join #(
        .N (NUM_PORTS)
    ) u_join (
        .have_tok  (have_tok),
        .tail_tok  (tail_tok),
        .out_ready (out_ready),
        .advance   (advance),
        .fire      (fire)
    );

    dfnode_madd_pipe #(
        .W   (DATA_W),
        .LAT (LAT)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .fire      (fire),
        .op_a      (head_data[PORT_A]),
        .op_b      (head_data[PORT_B]),
        .op_c      (head_data[PORT_C]),
        .tail_tok  (tail_tok),
        .tail_data (tail_data)
    );

    assign out_valid = tail_tok;
    assign out_data  = tail_data;
endmodule

// File: rtl/dfnode_wrap_chk.sv
module dfnode_wrap_chk #(
    parameter int unsigned LAT = 4,
    parameter int unsigned NP  = 3,
    parameter int unsigned W   = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          fire,
    input logic [NP-1:0] port_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [W-1:0]  out_data
);
    logic [31:0] inflight_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= '0;
        end else begin
            case ({fire, out_valid && out_ready})
                2'b10:   inflight_q <= inflight_q + 1;
                2'b01:   inflight_q <= inflight_q - 1;
                default: inflight_q <= inflight_q;
            endcase
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_valid); // R1
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
    AST_NO_FIRE_STALLED: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |-> !fire); // R6
    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst) inflight_q <= LAT); // R8
    AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst) out_valid |-> (inflight_q != 0)); // R8

    for (genvar g = 0; g < int'(NP); g++) begin : g_rdy
        AST_READY_RESTORE: assert property (@(posedge clk) disable iff (rst) (!port_ready[g] && fire) |=> port_ready[g]); // R5
    end
endmodule

bind dfnode_wrap dfnode_wrap_chk #(
    .LAT (LAT),
    .NP  (dfnode_pkg::NUM_PORTS),
    .W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .port_ready (port_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
);

// File: tb/dfnode_wrap_test.sv
module dfnode_wrap_test;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 32;
    localparam int LAT   = 4;
    localparam int DEPTH = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_data = '0, b_data = '0, c_data = '0;
    logic         a_valid = 1'b0, b_valid = 1'b0, c_valid = 1'b0;
    logic         a_ready, b_ready, c_ready;
    logic [W-1:0] out_data;
    logic         out_valid;
    logic         out_ready = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] mon_exp;

    dfnode_wrap #(.DATA_W(W), .LAT(LAT), .FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .a_data(a_data), .a_valid(a_valid), .a_ready(a_ready),
        .b_data(b_data), .b_valid(b_valid), .b_ready(b_ready),
        .c_data(c_data), .c_valid(c_valid), .c_ready(c_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [W-1:0] f_madd(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        logic [W-1:0] r;
        r = a * b + c;
        return r;
    endfunction

    function automatic logic [W-1:0] ga(input int i); return W'(i) * 32'h0001_0003 + 32'h11; endfunction
    function automatic logic [W-1:0] gb(input int i); return (W'(i) << 5) ^ 32'h0000_0F0F; endfunction
    function automatic logic [W-1:0] gc(input int i); return 32'h8000_0000 - W'(i) * 7; endfunction

    task automatic idle_inputs();
        a_valid = 1'b0; b_valid = 1'b0; c_valid = 1'b0;
    endtask

    task automatic drive3(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        a_data = a; b_data = b; c_data = c;
        a_valid = 1'b1; b_valid = 1'b1; c_valid = 1'b1;
    endtask

    // Result must show exactly after the LAT-th edge following acceptance
    task automatic wait_latency(input string req);
        for (int k = 0; k <= LAT; k++) begin
            tick();
            if (k == 0) idle_inputs();
            chk(out_valid == (k == LAT), req, W'(out_valid), W'(k == LAT));
        end
    endtask

    // In-order scoreboard at the output handshake (R2, R8)
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected output", out_data, '0);
            end else begin
                mon_exp = exp_q.pop_front();
                chk(out_data == mon_exp, "R2 R8 result value/order", out_data, mon_exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    task automatic t_reset();
        rst = 1'b1;
        idle_inputs();
        out_ready = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(out_valid == 1'b0, "R1 out_valid after reset", W'(out_valid), '0);
        chk({a_ready, b_ready, c_ready} == 3'b111, "R1 readies after reset", W'({a_ready, b_ready, c_ready}), W'(3'b111));
    endtask

    task automatic t_latency();
        out_ready = 1'b1;
        exp_q.push_back(f_madd(32'd7, 32'd6, 32'd5));
        drive3(32'd7, 32'd6, 32'd5);
        wait_latency("R3 latency");
        // overflow wrap of product and sum
        exp_q.push_back(f_madd(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF));
        drive3(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wait_latency("R3 R2 latency with wrap");
        tick();
    endtask

    task automatic t_join();
        out_ready = 1'b1;
        exp_q.push_back(f_madd(32'd123, 32'd456, 32'd789));
        a_data = 32'd123; b_data = 32'd456;
        a_valid = 1'b1; b_valid = 1'b1;
        tick();
        idle_inputs();
        for (int k = 0; k < 2 * LAT; k++) begin
            tick();
            chk(!out_valid, "R4 no fire on partial operands", W'(out_valid), '0);
        end
        chk({a_ready, b_ready, c_ready} == 3'b111, "R5 ready with one entry", W'({a_ready, b_ready, c_ready}), W'(3'b111));
        c_data = 32'd789;
        c_valid = 1'b1;
        wait_latency("R4 join completes");
        tick();
    endtask

    task automatic t_bubble();
        out_ready = 1'b0;
        exp_q.push_back(f_madd(32'd3, 32'd9, 32'd1));
        drive3(32'd3, 32'd9, 32'd1);
        wait_latency("R7 bubbles do not stall");
        out_ready = 1'b1;
        tick();
        tick();
        chk(!out_valid, "R7 result consumed", W'(out_valid), '0);
    endtask

    task automatic t_stall();
        logic [W-1:0] held;
        out_ready = 1'b0;
        exp_q.push_back(f_madd(ga(0), gb(0), gc(0)));
        drive3(ga(0), gb(0), gc(0));
        wait_latency("R7 first result under stall");
        held = out_data;
        exp_q.push_back(f_madd(ga(1), gb(1), gc(1)));
        drive3(ga(1), gb(1), gc(1));
        tick();
        chk({a_ready, b_ready, c_ready} == 3'b111, "R5 one entry ready", W'({a_ready, b_ready, c_ready}), W'(3'b111));
        exp_q.push_back(f_madd(ga(2), gb(2), gc(2)));
        drive3(ga(2), gb(2), gc(2));
        tick();
        chk({a_ready, b_ready, c_ready} == 3'b000, "R5 full drops ready", W'({a_ready, b_ready, c_ready}), '0);
        drive3(ga(3), gb(3), gc(3));
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(out_valid && out_data == held, "R6 output held during stall", out_data, held);
            chk({a_ready, b_ready, c_ready} == 3'b000, "R6 nothing drawn while stalled", W'({a_ready, b_ready, c_ready}), '0);
        end
        idle_inputs();
        out_ready = 1'b1;
        repeat (3 * LAT + 4) tick();
        chk(exp_q.size() == 0, "R8 stalled items drained in order", W'(exp_q.size()), '0);
    endtask

    task automatic t_stream();
        int n = 24;
        int cnt = 0;
        int first = -1;
        int last = -1;
        bit rdy_ok = 1'b1;
        out_ready = 1'b1;
        for (int t = 0; t < n + LAT + 4; t++) begin
            if (t < n) begin
                if ({a_ready, b_ready, c_ready} != 3'b111) rdy_ok = 1'b0;
                exp_q.push_back(f_madd(gc(t), ga(t), gb(t)));
                drive3(gc(t), ga(t), gb(t));
            end else begin
                idle_inputs();
            end
            tick();
            if (out_valid) begin
                cnt++;
                if (first < 0) first = t;
                last = t;
            end
        end
        chk(rdy_ok, "R9 ready never drops", W'(rdy_ok), 1);
        chk(cnt == n, "R9 result count", W'(cnt), W'(n));
        chk(last - first + 1 == n, "R9 back-to-back results", W'(last - first + 1), W'(n));
    endtask

    task automatic t_random();
        int n = 120;
        int ia = 0, ib = 0, ic = 0;
        int guard = 0;
        for (int i = 0; i < n; i++) exp_q.push_back(f_madd(gb(i), gc(i), ga(i)));
        while ((ia < n || ib < n || ic < n || exp_q.size() != 0) && guard < 4000) begin
            guard++;
            out_ready = ($urandom_range(0, 9) < 6);
            if (ia < n && $urandom_range(0, 9) < 6) begin
                a_valid = 1'b1; a_data = gb(ia);
                if (a_ready) ia++;
            end else a_valid = 1'b0;
            if (ib < n && $urandom_range(0, 9) < 5) begin
                b_valid = 1'b1; b_data = gc(ib);
                if (b_ready) ib++;
            end else b_valid = 1'b0;
            if (ic < n && $urandom_range(0, 9) < 7) begin
                c_valid = 1'b1; c_data = ga(ic);
                if (c_ready) ic++;
            end else c_valid = 1'b0;
            tick();
        end
        idle_inputs();
        out_ready = 1'b1;
        repeat (LAT + 4) tick();
        chk(ia == n && ib == n && ic == n, "R8 all operands accepted", W'(ia + ib + ic), W'(3 * n));
        chk(exp_q.size() == 0, "R8 every triple delivered once", W'(exp_q.size()), '0);
        chk(!out_valid, "R8 no extra result", W'(out_valid), '0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_join();
        t_bubble();
        t_stall();
        t_stream();
        t_random();
        finish_up();
    end
endmodule